// File: doc/BRIEF.md
# Register-Triggered Reset Sequencer

This block sits inside a system-management controller and turns register writes into reset sequences. One write-only control register carries command bits. Power-off and sleep-entry bits only produce strobes. Three reboot-type bits drive a chosen subset of three active-low resets: a main reset that goes to the power-management side, a secondary reset pin and an external memory reset pin. Once any reset is asserted, the block holds all asserted resets for a fixed number of timebase ticks and releases them together. After a longer tick delay it pulses a strobe that tells the controller to reinitialise its registers.

A second write-only register has two bits. One latches the main reset asserted permanently, and only the block's power-on reset clears that latch. The other bit requests a protected clock-control change through a strobe. All delays count pulses of a 1 kHz tick input, so the default hold is 5 ms and the default reinitialisation delay is 100 ms. Every reset output and every strobe comes straight from a flip-flop.

Top module: `rst_seq_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, all three reset outputs are high (released), `busy` is low and every strobe is low. The power-on reset also clears the permanent-main-reset latch.
- R2: A control write (`wr_sel`=0) with bit 0 set makes `pwroff_stb` high for exactly one cycle, in the cycle after the write edge. Bit 0 on its own asserts no reset and does not raise `busy`.
- R3: A control write with bit 1 set asserts `main_rst_n`, `sec_rst_n` and `mem_rst_n` (all low) from the cycle after the write edge. The same write gives a one-cycle `bootenv_clr_stb`.
- R4: A control write with bit 2 set asserts `sec_rst_n` and gives a one-cycle `slvreg_clr_stb`. It also asserts `mem_rst_n` only if `emu_mode` was high at the write edge. A later change of `emu_mode` has no effect on the running sequence.
- R5: A control write with bit 3 set asserts only `mem_rst_n`.
- R6: The asserted resets stay low through HOLD_TICKS tick pulses (default 5). They all go high together after the edge that samples the last of those ticks.
- R7: `reinit_stb` is high for one cycle after the edge that samples the REINIT_TICKS-th tick (default 100) following release. `busy` is high from the assertion edge until that same edge, where it falls.
- R8: When one control write sets several of bits 1 to 3, the asserted resets are the union of the subsets for those bits. A single hold and a single reinitialisation delay are run.
- R9: A control write accepted while `busy` is high, including the cycle in which `reinit_stb` fires, is ignored. It changes no reset and gives no strobe.
- R10: A control write with bit 4 set gives a one-cycle `sleep_stb` and asserts no reset. Bits 7 to 5 of a control write have no effect.
- R11: A kill write (`wr_sel`=1) with bit 0 set drives `main_rst_n` low from the cycle after the write edge. It stays low through any later sequence and its release, until `rst_n` is pulled low. Kill writes are accepted while `busy` is high.
- R12: A kill write with bit 1 set gives a one-cycle `rtc_prot_stb` and changes no reset output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 1 | Target register: 0 control, 1 kill |
| wr_data | input | DW (8) | Write data |
| emu_mode | input | 1 | Emulation-mode flag, sampled by bit 2 writes |
| tick | input | 1 | One-cycle pulse of the 1 kHz timebase |
| main_rst_n | output | 1 | Main reset command, active low |
| sec_rst_n | output | 1 | Secondary reset pin, active low |
| mem_rst_n | output | 1 | External memory reset pin, active low |
| busy | output | 1 | A reset sequence is running |
| pwroff_stb | output | 1 | Power-off request strobe |
| sleep_stb | output | 1 | Sleep-entry notification strobe |
| bootenv_clr_stb | output | 1 | Clear preserved boot-environment state |
| slvreg_clr_stb | output | 1 | Clear bus-slave registers |
| reinit_stb | output | 1 | Register-reinitialisation strobe |
| rtc_prot_stb | output | 1 | Protected clock-control bit and pin-direction request |

## Verification
The end of a sequence and a new control write can arrive at the same clock edge. The last reinitialisation tick frees the block in the same cycle that a fresh write is presented. The bench drives the 100th post-release tick and a memory-reset write in the same cycle. It then expects `reinit_stb` high, `busy` low and `mem_rst_n` still high, and it checks that no second sequence starts in the following cycles. A kill write is also placed in the middle of a hold, so that the release edge and the latched main reset meet.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    // control register bit positions
    localparam int unsigned CMD_PWROFF = 0;
    localparam int unsigned CMD_FULL   = 1;
    localparam int unsigned CMD_NORM   = 2;
    localparam int unsigned CMD_MEM    = 3;
    localparam int unsigned CMD_SLEEP  = 4;
    localparam int unsigned CMD_W      = 5;

    // kill register bit positions
    localparam int unsigned KILL_MAIN  = 0;
    localparam int unsigned KILL_RTC   = 1;
    localparam int unsigned KILL_W     = 2;

    typedef struct packed {
        logic main;
        logic sec;
        logic mem;
    } rst_mask_t;

    typedef struct packed {
        rst_mask_t mask;
        logic      pwroff;
        logic      sleep;
        logic      bootclr;
        logic      slvclr;
    } cmd_dec_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HOLD = 2'd1,
        SEQ_WAIT = 2'd2
    } seq_state_e;

    typedef struct packed {
        rst_mask_t mask;
        logic      main_n;
        logic      sec_n;
        logic      mem_n;
        logic      pwroff;
        logic      sleep;
        logic      bootclr;
        logic      slvclr;
        logic      reinit;
    } out_regs_t;

    localparam out_regs_t OUT_RST = '{
        mask:    '{main: 1'b0, sec: 1'b0, mem: 1'b0},
        main_n:  1'b1,
        sec_n:   1'b1,
        mem_n:   1'b1,
        pwroff:  1'b0,
        sleep:   1'b0,
        bootclr: 1'b0,
        slvclr:  1'b0,
        reinit:  1'b0
    };

    // reset subset requested by one reboot-type command bit
    function automatic rst_mask_t cmd_subset(input int unsigned idx, input logic emu);
        rst_mask_t m;
        m = '0;
        case (idx)
            CMD_FULL: m = '{main: 1'b1, sec: 1'b1, mem: 1'b1};
            CMD_NORM: m = '{main: 1'b0, sec: 1'b1, mem: emu};
            CMD_MEM:  m = '{main: 1'b0, sec: 1'b0, mem: 1'b1};
            default:  m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rst_seq_decode.sv
module rst_seq_decode
    import rst_seq_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    input  logic             emu,
    output cmd_dec_t         dec
);

    localparam int unsigned FIRST_RST = CMD_FULL;
    localparam int unsigned LAST_RST  = CMD_MEM;
    localparam int unsigned N_RST     = LAST_RST - FIRST_RST + 1;

    rst_mask_t part [N_RST];

    // one masked subset per reboot-type bit; the union is taken below
    for (genvar g = 0; g < N_RST; g++) begin : g_part
        always_comb begin
            part[g] = cmd[FIRST_RST + g] ? cmd_subset(FIRST_RST + g, emu) : '0;
        end
    end

    always_comb begin
        dec.mask = '0;
        for (int i = 0; i < N_RST; i++) begin
            dec.mask = dec.mask | part[i];
        end
        dec.pwroff  = cmd[CMD_PWROFF];
        dec.sleep   = cmd[CMD_SLEEP];
        dec.bootclr = cmd[CMD_FULL];
        dec.slvclr  = cmd[CMD_NORM];
    end

endmodule

// File: rtl/rst_seq_timer.sv
module rst_seq_timer
    import rst_seq_pkg::*;
#(
    parameter int unsigned HOLD_TICKS   = 5,
    parameter int unsigned REINIT_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic busy,
    output logic release_now,
    output logic reinit_now
);

    localparam int unsigned MAX_T = (HOLD_TICKS > REINIT_TICKS) ? HOLD_TICKS : REINIT_TICKS;
    localparam int unsigned CW    = (MAX_T < 2) ? 1 : $clog2(MAX_T);
    localparam logic [CW-1:0] HOLD_LAST   = CW'(HOLD_TICKS - 1);
    localparam logic [CW-1:0] REINIT_LAST = CW'(REINIT_TICKS - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d           = q;
        release_now = 1'b0;
        reinit_now  = 1'b0;
        case (q.state)
            SEQ_IDLE: begin
                if (start) begin
                    d.state = SEQ_HOLD;
                    d.cnt   = '0;
                end
            end
            SEQ_HOLD: begin
                if (tick) begin
                    if (q.cnt == HOLD_LAST) begin
                        release_now = 1'b1;
                        d.state     = SEQ_WAIT;
                        d.cnt       = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            SEQ_WAIT: begin
                if (tick) begin
                    if (q.cnt == REINIT_LAST) begin
                        reinit_now = 1'b1;
                        d.state    = SEQ_IDLE;
                        d.cnt      = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                d.state = SEQ_IDLE;
                d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: SEQ_IDLE, cnt: '0};
        end else begin
            q <= d;
        end
    end

    assign busy = (q.state != SEQ_IDLE);

endmodule

// File: rtl/rst_seq_kill.sv
module rst_seq_kill
    import rst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [KILL_W-1:0] data,
    output logic              kill_next,
    output logic              kill_q,
    output logic              rtc_stb
);

    typedef struct packed {
        logic kill;
        logic rtc;
    } kill_regs_t;

    kill_regs_t q, d;

    always_comb begin
        d.kill = q.kill | (wr & data[KILL_MAIN]);
        d.rtc  = wr & data[KILL_RTC];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign kill_next = d.kill;
    assign kill_q    = q.kill;
    assign rtc_stb   = q.rtc;

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
    import rst_seq_pkg::*;
#(
    parameter int unsigned DW           = 8,
    parameter int unsigned HOLD_TICKS   = 5,
    parameter int unsigned REINIT_TICKS = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          emu_mode,
    input  logic          tick,
    output logic          main_rst_n,
    output logic          sec_rst_n,
    output logic          mem_rst_n,
    output logic          busy,
    output logic          pwroff_stb,
    output logic          sleep_stb,
    output logic          bootenv_clr_stb,
    output logic          slvreg_clr_stb,
    output logic          reinit_stb,
    output logic          rtc_prot_stb
);

    logic unused_hi;
    assign unused_hi = ^wr_data[DW-1:CMD_W];

    cmd_dec_t  dec;
    logic      tmr_busy;
    logic      release_now;
    logic      reinit_now;
    logic      kill_next;
    logic      kill_q;
    logic      ctrl_accept;
    logic      seq_start;
    out_regs_t q, d;

    rst_seq_decode u_decode (
        .cmd (wr_data[CMD_W-1:0]),
        .emu (emu_mode),
        .dec (dec)
    );

    rst_seq_kill u_kill (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_en & wr_sel),
        .data      (wr_data[KILL_W-1:0]),
        .kill_next (kill_next),
        .kill_q    (kill_q),
        .rtc_stb   (rtc_prot_stb)
    );

    rst_seq_timer #(
        .HOLD_TICKS   (HOLD_TICKS),
        .REINIT_TICKS (REINIT_TICKS)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (seq_start),
        .tick        (tick),
        .busy        (tmr_busy),
        .release_now (release_now),
        .reinit_now  (reinit_now)
    );

    always_comb begin
        ctrl_accept = wr_en & ~wr_sel & ~tmr_busy;
        seq_start   = ctrl_accept & (|dec.mask);

        d = q;
        if (seq_start) begin
            d.mask = dec.mask;
        end else if (release_now) begin
            d.mask = '0;
        end

        d.main_n  = ~(d.mask.main | kill_next);
        d.sec_n   = ~d.mask.sec;
        d.mem_n   = ~d.mask.mem;

        d.pwroff  = ctrl_accept & dec.pwroff;
        d.sleep   = ctrl_accept & dec.sleep;
        d.bootclr = ctrl_accept & dec.bootclr;
        d.slvclr  = ctrl_accept & dec.slvclr;
        d.reinit  = reinit_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= OUT_RST;
        end else begin
            q <= d;
        end
    end

    assign main_rst_n      = q.main_n;
    assign sec_rst_n       = q.sec_n;
    assign mem_rst_n       = q.mem_n;
    assign busy            = tmr_busy;
    assign pwroff_stb      = q.pwroff;
    assign sleep_stb       = q.sleep;
    assign bootenv_clr_stb = q.bootclr;
    assign slvreg_clr_stb  = q.slvclr;
    assign reinit_stb      = q.reinit;

endmodule

// File: rtl/rst_seq_checker.sv
module rst_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic wr_sel,
    input logic main_rst_n,
    input logic sec_rst_n,
    input logic mem_rst_n,
    input logic busy,
    input logic pwroff_stb,
    input logic sleep_stb,
    input logic reinit_stb,
    input logic rtc_prot_stb
);

    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sec_rst_n && mem_rst_n));

    a_r6_release_together: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sec_rst_n) || $rose(mem_rst_n)) |-> (sec_rst_n && mem_rst_n));

    a_r7_busy_ends_on_reinit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> reinit_stb);

    a_r7_reinit_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_stb |-> !busy);

    a_r9_start_from_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && !wr_sel));

    a_r11_kill_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_rst_n && !busy) |=> !main_rst_n);

    a_r2_pwroff_single: assert property (@(posedge clk) disable iff (!rst_n)
        pwroff_stb |=> !pwroff_stb);

    a_r10_sleep_single: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_stb |=> !sleep_stb);

    a_r12_rtc_single: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_prot_stb |=> !rtc_prot_stb);

endmodule

bind rst_seq_top rst_seq_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .main_rst_n   (main_rst_n),
    .sec_rst_n    (sec_rst_n),
    .mem_rst_n    (mem_rst_n),
    .busy         (busy),
    .pwroff_stb   (pwroff_stb),
    .sleep_stb    (sleep_stb),
    .reinit_stb   (reinit_stb),
    .rtc_prot_stb (rtc_prot_stb)
);

// File: tb/rst_seq_top_tb_top.sv
module rst_seq_top_tb_top;

    localparam int HOLD   = 5;
    localparam int REINIT = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       emu_mode = 1'b0;
    logic       tick = 1'b0;
    logic       main_rst_n, sec_rst_n, mem_rst_n, busy;
    logic       pwroff_stb, sleep_stb, bootenv_clr_stb, slvreg_clr_stb, reinit_stb, rtc_prot_stb;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    rst_seq_top #(.DW(8), .HOLD_TICKS(HOLD), .REINIT_TICKS(REINIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .emu_mode(emu_mode), .tick(tick),
        .main_rst_n(main_rst_n), .sec_rst_n(sec_rst_n), .mem_rst_n(mem_rst_n), .busy(busy),
        .pwroff_stb(pwroff_stb), .sleep_stb(sleep_stb), .bootenv_clr_stb(bootenv_clr_stb),
        .slvreg_clr_stb(slvreg_clr_stb), .reinit_stb(reinit_stb), .rtc_prot_stb(rtc_prot_stb)
    );

    function automatic logic [2:0] rsts();
        return {main_rst_n, sec_rst_n, mem_rst_n};
    endfunction

    function automatic logic [5:0] stbs();
        return {pwroff_stb, sleep_stb, bootenv_clr_stb, slvreg_clr_stb, reinit_stb, rtc_prot_stb};
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic power_on();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_seq(input string req, input logic [2:0] held);
        ticks(HOLD - 1);
        chk(req, "held before last hold tick", {5'b0, rsts()}, {5'b0, held});
        ticks(1);
        chk(req, "released after hold", {5'b0, rsts()}, {5'b0, 3'b111});
        ticks(REINIT - 1);
        chk(req, "no reinit early / busy", {6'b0, reinit_stb, busy}, 8'b01);
        ticks(1);
        chk(req, "reinit fires, busy drops", {6'b0, reinit_stb, busy}, 8'b10);
        @(negedge clk);
        chk(req, "reinit one cycle", {7'b0, reinit_stb}, 8'b0);
    endtask

    task automatic t_reset();
        chk("R1", "resets after power-on", {5'b0, rsts()}, 8'b111);
        chk("R1", "strobes/busy after power-on", {1'b0, busy, stbs()}, 8'b0);
    endtask

    task automatic t_pwroff();
        do_write(1'b0, 8'h01);
        chk("R2", "pwroff strobe", {2'b0, stbs()}, 8'b100000);
        chk("R2", "no reset no busy", {4'b0, busy, rsts()}, 8'b0111);
        @(negedge clk);
        chk("R2", "pwroff one cycle", {7'b0, pwroff_stb}, 8'b0);
    endtask

    task automatic t_full();
        do_write(1'b0, 8'h02);
        chk("R3", "all resets low", {4'b0, busy, rsts()}, 8'b1000);
        chk("R3", "bootenv clear strobe", {2'b0, stbs()}, 8'b001000);
        finish_seq("R6/R7 full", 3'b000);
    endtask

    task automatic t_norm(input logic emu);
        emu_mode = emu;
        do_write(1'b0, 8'h04);
        emu_mode = ~emu;
        chk("R4", "normal reboot subset", {5'b0, rsts()}, {5'b0, 2'b10, ~emu});
        chk("R4", "slave clear strobe", {2'b0, stbs()}, 8'b000100);
        ticks(2);
        chk("R4", "emu change ignored", {5'b0, rsts()}, {5'b0, 2'b10, ~emu});
        ticks(HOLD - 2);
        chk("R6", "released", {5'b0, rsts()}, 8'b111);
        ticks(REINIT);
        chk("R7", "reinit after normal", {6'b0, reinit_stb, busy}, 8'b10);
        emu_mode = 1'b0;
    endtask

    task automatic t_mem();
        do_write(1'b0, 8'h08);
        chk("R5", "memory only", {4'b0, busy, rsts()}, 8'b1110);
        finish_seq("R5", 3'b110);
    endtask

    task automatic t_union_and_busy();
        do_write(1'b0, 8'h0C);
        chk("R8", "union of 2 and 3", {5'b0, rsts()}, 8'b100);
        ticks(2);
        do_write(1'b0, 8'h12);
        chk("R9", "write in hold ignored", {2'b0, stbs()}, 8'b0);
        chk("R9", "main untouched in hold", {7'b0, main_rst_n}, 8'b1);
        ticks(HOLD - 2);
        chk("R8", "single hold release", {5'b0, rsts()}, 8'b111);
        ticks(3);
        do_write(1'b0, 8'h08);
        chk("R9", "write in delay ignored", {4'b0, busy, rsts()}, 8'b1111);
        ticks(REINIT - 4);
        // last tick and a new write land on the same edge
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h08;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk("R7", "reinit at same edge", {6'b0, reinit_stb, busy}, 8'b10);
        chk("R9", "write at reinit edge ignored", {5'b0, rsts()}, 8'b111);
        repeat (3) @(negedge clk);
        chk("R9", "no late start", {4'b0, busy, rsts()}, 8'b0111);
    endtask

    task automatic t_sleep();
        do_write(1'b0, 8'hF0);
        chk("R10", "sleep strobe only", {2'b0, stbs()}, 8'b010000);
        chk("R10", "no reset from sleep/high bits", {4'b0, busy, rsts()}, 8'b0111);
        @(negedge clk);
        chk("R10", "sleep one cycle", {7'b0, sleep_stb}, 8'b0);
    endtask

    task automatic t_kill();
        do_write(1'b1, 8'h02);
        chk("R12", "rtc strobe", {2'b0, stbs()}, 8'b000001);
        chk("R12", "no reset from rtc", {4'b0, busy, rsts()}, 8'b0111);
        do_write(1'b0, 8'h02);
        ticks(2);
        do_write(1'b1, 8'h01);
        chk("R11", "kill accepted while busy", {4'b0, busy, rsts()}, 8'b1000);
        ticks(HOLD - 2);
        chk("R11", "main stays low on release", {5'b0, rsts()}, 8'b011);
        ticks(REINIT);
        repeat (4) @(negedge clk);
        chk("R11", "main low after sequence", {4'b0, busy, rsts()}, 8'b0011);
        power_on();
        chk("R1", "power-on clears kill", {5'b0, rsts()}, 8'b111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pwroff();
        t_full();
        t_norm(1'b0);
        t_norm(1'b1);
        t_mem();
        t_union_and_busy();
        t_sleep();
        t_kill();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule